// File: doc/BRIEF.md
# Packed Signed Byte Minimum Unit

This block is one SIMD execution slice. It takes two 256-bit operands and the old contents of the destination register. It writes back the lane-by-lane minimum, treating each byte as a two's-complement signed integer. A two-bit mode input selects how the upper 128 bits are treated: kept from the old destination, forced to zero, or computed like the lower half. In the legacy 128-bit mode the old destination takes the place of the first source, as a two-operand form requires.

A request is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. The result, the write enable and the fault flag are registered, and they appear with `out_valid` one cycle after acceptance. The output side applies back-pressure. While `out_valid` is high and `out_ready` is low, the output register holds its value and `in_ready` is low, so any input offered in that cycle is not taken. `in_ready` equals `!out_valid || out_ready`, so a new request can be accepted in the same cycle the previous result drains.

An illegal encoding does not produce a result. It returns a faulting response: `fault` is high, `wr_en` is low, and `result` carries the old destination unchanged. The operation changes no status flags and signals no floating-point exceptions, so the block has no outputs for them.

Top module: `sbmin_unit`

## Requirements
- R1: Each of the 32 byte lanes is compared as a signed 8-bit value. The smaller value is written to that lane, and on a tie the byte from `src_b` is chosen. The extremes 0x80 (-128) and 0x7F (+127) compare as signed values.
- R2: With `mode` = 2'b00 and `len_bit` = 0, result bits 127:0 are the lane minimum of `prior_dst` and `src_b`. Result bits 255:128 equal `prior_dst[255:128]`. `src_a` has no effect.
- R3: With `mode` = 2'b01 and `len_bit` = 0, result bits 127:0 are the lane minimum of `src_a` and `src_b`, and result bits 255:128 are zero.
- R4: With `mode` = 2'b10, all 32 lanes are the minimum of `src_a` and `src_b`. `len_bit` has no effect and no fault is raised.
- R5: With `mode` = 2'b00 or 2'b01 and `len_bit` = 1, the response has `fault` = 1, `wr_en` = 0 and `result` equal to `prior_dst`.
- R6: With `mode` = 2'b11, the response has `fault` = 1, `wr_en` = 0 and `result` equal to `prior_dst`, whatever the value of `len_bit`.
- R7: An accepted request drives `out_valid` high on the next cycle. In that cycle `wr_en` equals `!fault`. `wr_en` and `fault` are never high while `out_valid` is low.
- R8: While `out_valid` = 1 and `out_ready` = 0, `result`, `wr_en` and `fault` hold their values and `in_ready` = 0. `in_ready` equals `!out_valid || out_ready`.
- R9: Synchronous active-low reset clears `out_valid`, `wr_en` and `fault` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| mode | input | 2 | 00 legacy keep-upper, 01 zero-upper, 10 full width, 11 reserved |
| len_bit | input | 1 | Vector-length bit from the encoding |
| src_a | input | 256 | First source operand |
| src_b | input | 256 | Second source operand |
| prior_dst | input | 256 | Old destination register value |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| wr_en | output | 1 | Result is to be written back |
| fault | output | 1 | Undefined-opcode fault |
| result | output | 256 | Registered result |

## Verification
The lane comparison is driven with these patterns, and each one separates a different kind of error:
- Opposite extremes (0x80 against 0x7F) set apart a signed comparator from an unsigned one.
- Lanes of mixed sign with small magnitudes expose a comparator that looks only at the magnitude bits.
- Equal bytes exercise the tie rule.
- A descending ramp against an ascending one catches swapped or misplaced lanes.

Random vectors in every mode, with `src_a` and `prior_dst` set to different values, show whether the first operand or the old destination feeds the low half. They also show how the upper half is treated in each mode. Random stalls on `out_ready` show that a held response does not change and that inputs offered during a stall are not lost.

// File: rtl/sbmin_pkg.sv
package sbmin_pkg;

  typedef enum logic [1:0] {
    MD_KEEP = 2'b00,
    MD_ZERO = 2'b01,
    MD_WIDE = 2'b10,
    MD_RSVD = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    UP_KEEP = 2'b00,
    UP_ZERO = 2'b01,
    UP_CALC = 2'b10
  } upper_t;

  typedef struct packed {
    logic   fault;
    logic   first_is_dst;
    upper_t upper;
  } dec_t;

endpackage

// File: rtl/sbmin_decode.sv
module sbmin_decode
  import sbmin_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       len_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o = '{fault: 1'b1, first_is_dst: 1'b0, upper: UP_KEEP};
    unique case (mode_t'(mode_i))
      MD_KEEP: begin
        dec_o.first_is_dst = 1'b1;
        dec_o.upper        = UP_KEEP;
        dec_o.fault        = len_i;
      end
      MD_ZERO: begin
        dec_o.upper = UP_ZERO;
        dec_o.fault = len_i;
      end
      MD_WIDE: begin
        dec_o.upper = UP_CALC;
        dec_o.fault = 1'b0;
      end
      default: begin
        dec_o.fault = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sbmin_lane.sv
module sbmin_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] y_o
);

  logic a_less;

  // Strictly-less picks a; a tie falls through to b.
  assign a_less = $signed(a_i) < $signed(b_i);
  assign y_o    = a_less ? a_i : b_i;

endmodule

// File: rtl/sbmin_lanes.sv
module sbmin_lanes #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] min_o
);

  localparam int NLANES = VEC_W / LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    sbmin_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i (a_i[g*LANE_W +: LANE_W]),
      .b_i (b_i[g*LANE_W +: LANE_W]),
      .y_o (min_o[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sbmin_merge.sv
module sbmin_merge
  import sbmin_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  dec_t             dec_i,
  input  logic [VEC_W-1:0] min_i,
  input  logic [VEC_W-1:0] old_i,
  output logic [VEC_W-1:0] res_o
);

  localparam int HALF_W = VEC_W / 2;

  always_comb begin
    if (dec_i.fault) begin
      res_o = old_i;
    end else begin
      res_o[HALF_W-1:0] = min_i[HALF_W-1:0];
      unique case (dec_i.upper)
        UP_KEEP: res_o[VEC_W-1:HALF_W] = old_i[VEC_W-1:HALF_W];
        UP_ZERO: res_o[VEC_W-1:HALF_W] = '0;
        default: res_o[VEC_W-1:HALF_W] = min_i[VEC_W-1:HALF_W];
      endcase
    end
  end

endmodule

// File: rtl/sbmin_unit.sv
module sbmin_unit
  import sbmin_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       mode,
  input  logic             len_bit,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] prior_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             wr_en,
  output logic             fault,
  output logic [VEC_W-1:0] result
);

  dec_t             dec;
  logic [VEC_W-1:0] first_op;
  logic [VEC_W-1:0] lane_min;
  logic [VEC_W-1:0] next_res;
  logic             accept;

  sbmin_decode u_dec (
    .mode_i (mode),
    .len_i  (len_bit),
    .dec_o  (dec)
  );

  assign first_op = dec.first_is_dst ? prior_dst : src_a;

  sbmin_lanes #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_lanes (
    .a_i   (first_op),
    .b_i   (src_b),
    .min_o (lane_min)
  );

  sbmin_merge #(.VEC_W(VEC_W)) u_merge (
    .dec_i (dec),
    .min_i (lane_min),
    .old_i (prior_dst),
    .res_o (next_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      fault     <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      wr_en     <= !dec.fault;
      fault     <= dec.fault;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      fault     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) result <= next_res;
  end

endmodule

// File: rtl/sbmin_unit_sva.sv
module sbmin_unit_sva #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       mode,
  input logic             len_bit,
  input logic [VEC_W-1:0] prior_dst,
  input logic             out_valid,
  input logic             out_ready,
  input logic             wr_en,
  input logic             fault,
  input logic [VEC_W-1:0] result
);

  localparam int HALF_W = VEC_W / 2;

  logic acc;
  assign acc = in_valid && in_ready;

  assert_keep_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 2'b00 && !len_bit |=>
      result[VEC_W-1:HALF_W] == $past(prior_dst[VEC_W-1:HALF_W]));

  assert_zero_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 2'b01 && !len_bit |=> result[VEC_W-1:HALF_W] == '0 && wr_en);

  assert_wide_nofault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 2'b10 |=> out_valid && !fault && wr_en);

  assert_len_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mode[1] && len_bit |=> fault && !wr_en && result == $past(prior_dst));

  assert_rsvd_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 2'b11 |=> fault && !wr_en && result == $past(prior_dst));

  assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || fault) |-> out_valid && (wr_en != fault));

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(wr_en) && $stable(fault));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !wr_en && !fault);

endmodule

bind sbmin_unit sbmin_unit_sva #(.VEC_W(VEC_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mode      (mode),
  .len_bit   (len_bit),
  .prior_dst (prior_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .wr_en     (wr_en),
  .fault     (fault),
  .result    (result)
);

// File: tb/sbmin_unit_tb.sv
module sbmin_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   mode = '0;
  logic         len_bit = 1'b0;
  logic [255:0] src_a = '0, src_b = '0, prior_dst = '0;
  logic         out_valid, out_ready = 1'b1, wr_en, fault;
  logic [255:0] result;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int ready_pct = 100;
  string dir_tag = "";

  // reference model state
  bit           m_valid = 0, m_wr = 0, m_fault = 0, m_stall = 0;
  logic [255:0] m_res = '0;
  string        m_tag = "R7";

  always #4 clk = ~clk;

  sbmin_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .len_bit(len_bit), .src_a(src_a), .src_b(src_b),
    .prior_dst(prior_dst), .out_valid(out_valid), .out_ready(out_ready),
    .wr_en(wr_en), .fault(fault), .result(result)
  );

  function automatic logic [255:0] ref_calc(input int md, input bit ln,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] d,
      output bit flt);
    logic [255:0] r;
    int top;
    flt = (md == 3) || (md < 2 && ln);
    if (flt) return d;
    if (md == 0) a = d;
    r = (md == 0) ? d : '0;
    top = (md == 2) ? 32 : 16;
    for (int i = 0; i < top; i++) begin
      int x, y;
      x = int'($signed(a[i*8 +: 8]));
      y = int'($signed(b[i*8 +: 8]));
      r[i*8 +: 8] = (x < y) ? a[i*8 +: 8] : b[i*8 +: 8];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_wr = 0; m_fault = 0; m_stall = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      bit f;
      m_res   = ref_calc(int'(mode), len_bit, src_a, src_b, prior_dst, f);
      m_valid = 1; m_fault = f; m_wr = !f; m_stall = 0;
      if (f) m_tag = (mode == 2'b11) ? "R6" : "R5";
      else if (dir_tag != "") m_tag = dir_tag;
      else m_tag = (mode == 2'b00) ? "R2" : (mode == 2'b01) ? "R3" : "R4";
    end else if (out_ready) begin
      m_valid = 0; m_wr = 0; m_fault = 0; m_stall = 0;
    end else if (m_valid) begin
      m_stall = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R7 / R8: handshake and flags
      check(out_valid === m_valid && wr_en === m_wr && fault === m_fault &&
            in_ready === (!m_valid || out_ready), m_stall ? "R8" : "R7",
            {252'd0, out_valid, wr_en, fault, in_ready},
            {252'd0, m_valid, m_wr, m_fault, !m_valid || out_ready});
      if (m_valid)
        check(result === m_res, m_stall ? "R8" : m_tag, result, m_res);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic step();
    @(negedge clk); #1;
    out_ready = ($urandom_range(99) < ready_pct);
    #1;
  endtask

  task automatic send(input logic [1:0] md, input bit ln, input logic [255:0] a,
                      input logic [255:0] b, input logic [255:0] d);
    bit acc;
    mode = md; len_bit = ln; src_a = a; src_b = b; prior_dst = d;
    in_valid = 1'b1;
    forever begin
      acc = in_ready;
      step();
      if (acc) break;
    end
    in_valid = 1'b0;
    src_a = rnd256(); src_b = rnd256(); prior_dst = rnd256();
  endtask

  initial begin
    logic [255:0] lo, hi, mix, up, dn;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9: reset state
    check(out_valid === 1'b0 && wr_en === 1'b0 && fault === 1'b0, "R9",
          {253'd0, out_valid, wr_en, fault}, '0);

    // R1 directed extremes
    lo = {32{8'h80}}; hi = {32{8'h7F}};
    for (int i = 0; i < 32; i++) begin
      mix[i*8 +: 8] = (i % 2) ? 8'hFF : 8'h01;
      up[i*8 +: 8]  = 8'(i * 8 - 128);
      dn[i*8 +: 8]  = 8'(127 - i * 8);
    end
    dir_tag = "R1";
    send(2'b10, 0, lo, hi, rnd256());
    send(2'b10, 0, hi, lo, rnd256());
    send(2'b10, 0, mix, ~mix, rnd256());
    send(2'b10, 0, mix, {32{8'h00}}, rnd256());
    send(2'b10, 0, up, dn, rnd256());
    send(2'b10, 0, hi, hi, rnd256());
    send(2'b01, 0, lo, hi, rnd256());
    send(2'b00, 0, rnd256(), hi, lo);
    dir_tag = "";

    // every mode, random, with and without stalls
    for (int pass = 0; pass < 2; pass++) begin
      ready_pct = pass ? 60 : 100;
      for (int n = 0; n < 120; n++) begin
        logic [1:0] md;
        md = 2'($urandom_range(3));
        send(md, ($urandom_range(3) == 0), rnd256(), rnd256(), rnd256());
      end
    end

    // R5 / R6 targeted
    ready_pct = 100;
    send(2'b00, 1, rnd256(), rnd256(), rnd256());
    send(2'b01, 1, rnd256(), rnd256(), rnd256());
    send(2'b11, 0, rnd256(), rnd256(), rnd256());
    send(2'b11, 1, rnd256(), rnd256(), rnd256());
    send(2'b10, 1, rnd256(), rnd256(), rnd256());

    // R8: long stall, then R9 mid-flight reset
    ready_pct = 0;
    send(2'b10, 0, rnd256(), rnd256(), rnd256());
    in_valid = 1'b1; mode = 2'b01;
    repeat (4) step();
    in_valid = 1'b0;
    rst_n = 1'b0;
    step();
    check(out_valid === 1'b0 && wr_en === 1'b0 && fault === 1'b0, "R9",
          {253'd0, out_valid, wr_en, fault}, '0);
    rst_n = 1'b1;
    ready_pct = 100;
    repeat (3) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule